// File: doc/BRIEF.md
# Frame writeback capture controller

This block is the control side of a writeback engine that writes one composited frame to memory. Software programs a destination base, a line stride and the frame dimensions through a small word-addressed register bus, then writes a start bit. The data path reports each line it has committed with a one-cycle strobe. In response the controller keeps a count of finished lines and gives the base address of the next line to write. When the programmed number of lines is done, the controller goes idle and can raise an interrupt.

Software can stop a frame early with an abort bit. It can ask for a new frame-start request to be issued at the end of each frame. It also controls a sleep request for the engine's internal memory. The control word carries a fixed identification pattern in its top bits, and these bits cannot be written. The pixel path, tiled layouts and the bus master are outside this block.

Top module: `wbcap_ctrl`

## Requirements
- R1: After reset, every register reads 0 except the control word, which reads 0x5440_0000. `frame_busy`, `irq`, `frame_start`, `mem_sleep` and `line_addr` are all 0.
- R2: The register map is word-addressed: base at 0x00, stride at 0x04, size at 0x08, control at 0x0C, progress at 0x10. Bits 1:0 of the base and bits 3:0 of the stride always read 0. The base and stride hold PTR_W bits and are zero-extended on read. The size word keeps line count in bits 31:16 and line width in bits 15:0, and reads back exactly as written.
- R3: In the control word, bits 31:24 read 0x54 and bits 23:22 read 0b01 whatever is written. Bit 0 (start) always reads 0 and bit 1 reads the busy state. Bits 2 (irq enable), 15 (rearm) and 21 (sleep) read back as written. All other bits read 0.
- R4: A control write with bit 0 set and bit 14 clear, made while idle with a nonzero line count, starts a frame. On the next edge busy is 1, progress is 0, `line_addr` equals the base, and `frame_start` pulses for one cycle.
- R5: Each `line_done` strobe while busy adds 1 to progress and adds the stride to `line_addr`, modulo 2^PTR_W.
- R6: The strobe that brings progress up to the line count clears busy on the same edge. Progress keeps that value afterwards.
- R7: A start is ignored while busy. It is also ignored when the line count is 0.
- R8: `line_done` while idle changes neither progress nor `line_addr`.
- R9: A control write with bit 14 set while busy ends the frame on the next edge. Progress keeps the count reached, and later strobes are ignored. A start written in the same word as an abort is ignored.
- R10: `irq` is 1 while bit 2 is set and a frame has ended, either by completion or by abort, since the last start. It drops when bit 2 is cleared or when a new frame starts.
- R11: With bit 15 set, `frame_start` pulses for one cycle on the edge where a frame completes normally. It does not pulse on an abort.
- R12: `mem_sleep` follows control bit 21, and `frame_busy` is 1 exactly while a frame is in progress.
- R13: Writes to base, stride or size are ignored while busy.
- R14: Offsets above 0x10 and offsets that are not word-aligned read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| line_done | input | 1 | One-cycle strobe: a line has been committed to memory |
| line_addr | output | PTR_W | Base address of the line now being written |
| frame_start | output | 1 | One-cycle frame-start request to the compositor |
| frame_busy | output | 1 | Frame in progress; memory writes permitted |
| mem_sleep | output | 1 | Sleep request for the internal line memory |
| irq | output | 1 | Idle interrupt, level |

## Verification
The bench builds the block with PTR_W = 16 and the default ADDR_W = 5. The narrow pointer lets a high base plus a few large strides wrap the line address, so the modulo rule is observed directly. The sweep covers two bases, three strides, line counts 1 to 4 and both rearm settings, which places every frame's last-line edge, the mid-frame ignored start and the ignored configuration writes within a few cycles of one another. Abort, zero height, start-with-abort and misaligned offsets are each driven once at their boundaries.

// File: rtl/wbcap_pkg.sv
// Shared constants for the writeback capture controller: word indices of the
// register map, control-bit positions and the fixed identification field.
package wbcap_pkg;
    localparam int REG_W  = 32;
    localparam int PROG_W = 16;

    // Word indices (byte offset / 4).
    localparam int IDX_BASE   = 0;
    localparam int IDX_STRIDE = 1;
    localparam int IDX_SIZE   = 2;
    localparam int IDX_CTRL   = 3;
    localparam int IDX_PROG   = 4;

    // Control-word bit positions.
    localparam int B_START  = 0;
    localparam int B_BUSY   = 1;
    localparam int B_IRQEN  = 2;
    localparam int B_ABORT  = 14;
    localparam int B_REARM  = 15;
    localparam int B_SLEEP  = 21;

    localparam logic [7:0] ID_TAG = 8'h54;
    localparam logic [1:0] ID_REV = 2'b01;

    // Low address bits forced to zero.
    localparam int BASE_ALIGN_BITS   = 2;
    localparam int STRIDE_ALIGN_BITS = 4;

    typedef struct packed {
        logic sleep;
        logic rearm;
        logic irq_en;
    } ctrl_t;
endpackage

// File: rtl/wbcap_regs.sv
// Register file of the capture controller.
// Holds base, stride, size and the control flags; decodes start/abort
// commands as single-cycle requests and builds the read word.
// Assumes word-aligned offsets; any other offset is unmapped.
module wbcap_regs
    import wbcap_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int PTR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              busy,
    input  logic [PROG_W-1:0] prog,
    output logic [PTR_W-1:0]  base,
    output logic [PTR_W-1:0]  stride,
    output logic [15:0]       height,
    output ctrl_t             ctrl,
    output logic              go_req,
    output logic              abort_req
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [PTR_W-1:0] BASE_MASK   = ~PTR_W'((1 << BASE_ALIGN_BITS) - 1);
    localparam logic [PTR_W-1:0] STRIDE_MASK = ~PTR_W'((1 << STRIDE_ALIGN_BITS) - 1);

    logic [IDX_W-1:0] idx;
    logic             aligned;
    logic             sel_base, sel_stride, sel_size, sel_ctrl, sel_prog;
    logic [15:0]      width;

    assign idx     = reg_addr[ADDR_W-1:2];
    assign aligned = (reg_addr[1:0] == 2'b00);

    // Decode the addressed register.
    always_comb begin
        sel_base   = aligned && (idx == IDX_W'(IDX_BASE));
        sel_stride = aligned && (idx == IDX_W'(IDX_STRIDE));
        sel_size   = aligned && (idx == IDX_W'(IDX_SIZE));
        sel_ctrl   = aligned && (idx == IDX_W'(IDX_CTRL));
        sel_prog   = aligned && (idx == IDX_W'(IDX_PROG));
    end

    // Command requests, valid only in the write cycle.
    assign go_req    = reg_we && sel_ctrl && reg_wdata[B_START];
    assign abort_req = reg_we && sel_ctrl && reg_wdata[B_ABORT];

    // Frame configuration: frozen while a frame runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base   <= '0;
            stride <= '0;
            height <= '0;
            width  <= '0;
        end else if (reg_we && !busy) begin
            if (sel_base)   base   <= reg_wdata[PTR_W-1:0] & BASE_MASK;
            if (sel_stride) stride <= reg_wdata[PTR_W-1:0] & STRIDE_MASK;
            if (sel_size) begin
                height <= reg_wdata[31:16];
                width  <= reg_wdata[15:0];
            end
        end
    end

    // Control flags: writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (reg_we && sel_ctrl) begin
            ctrl.sleep  <= reg_wdata[B_SLEEP];
            ctrl.rearm  <= reg_wdata[B_REARM];
            ctrl.irq_en <= reg_wdata[B_IRQEN];
        end
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (sel_base)   reg_rdata = REG_W'(base);
        if (sel_stride) reg_rdata = REG_W'(stride);
        if (sel_size)   reg_rdata = {height, width};
        if (sel_prog)   reg_rdata = REG_W'(prog);
        if (sel_ctrl) begin
            reg_rdata[31:24]   = ID_TAG;
            reg_rdata[23:22]   = ID_REV;
            reg_rdata[B_SLEEP] = ctrl.sleep;
            reg_rdata[B_REARM] = ctrl.rearm;
            reg_rdata[B_IRQEN] = ctrl.irq_en;
            reg_rdata[B_BUSY]  = busy;
        end
    end
endmodule

// File: rtl/wbcap_frame.sv
// Frame sequencer: owns the busy flag and the committed-line count.
// Emits the frame-start request and the idle interrupt.
// Assumes line_done is a one-cycle strobe per committed line.
module wbcap_frame
    import wbcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_req,
    input  logic              abort_req,
    input  logic              line_done,
    input  logic [15:0]       height,
    input  ctrl_t             ctrl,
    output logic              busy,
    output logic [PROG_W-1:0] prog,
    output logic              frame_start,
    output logic              irq,
    output logic              load,
    output logic              step
);
    logic ended;
    logic last_line;

    // Qualified events for this cycle.
    assign load      = go_req && !abort_req && !busy && (height != 16'd0);
    assign step      = busy && line_done && !abort_req;
    assign last_line = ((prog + PROG_W'(1)) == PROG_W'(height));

    // Frame state: abort outranks start, start outranks line counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            prog        <= '0;
            ended       <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            frame_start <= 1'b0;
            if (busy && abort_req) begin
                busy  <= 1'b0;
                ended <= 1'b1;
            end else if (load) begin
                busy        <= 1'b1;
                prog        <= '0;
                ended       <= 1'b0;
                frame_start <= 1'b1;
            end else if (step) begin
                prog <= prog + PROG_W'(1);
                if (last_line) begin
                    busy        <= 1'b0;
                    ended       <= 1'b1;
                    frame_start <= ctrl.rearm;
                end
            end
        end
    end

    // Level interrupt while enabled and a frame has ended.
    assign irq = ctrl.irq_en && ended;
endmodule

// File: rtl/wbcap_addr.sv
// Line address accumulator: loads the base at frame start and adds the stride
// on every committed line, wrapping modulo 2^PTR_W.
module wbcap_addr #(
    parameter int PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [PTR_W-1:0] base,
    input  logic [PTR_W-1:0] stride,
    output logic [PTR_W-1:0] line_addr
);
    // Accumulate base + n * stride without a multiplier.
    always_ff @(posedge clk) begin
        if (!rst_n)    line_addr <= '0;
        else if (load) line_addr <= base;
        else if (step) line_addr <= line_addr + stride;
    end
endmodule

// File: rtl/wbcap_ctrl.sv
// Top of the frame writeback capture controller.
// Connects the register file, the frame sequencer and the line address
// accumulator. Memory writes are allowed exactly while a frame is busy.
module wbcap_ctrl
    import wbcap_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int PTR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              line_done,
    output logic [PTR_W-1:0]  line_addr,
    output logic              frame_start,
    output logic              frame_busy,
    output logic              mem_sleep,
    output logic              irq
);
    logic [PTR_W-1:0]  base, stride;
    logic [15:0]       height;
    ctrl_t             ctrl;
    logic              go_req, abort_req, busy, load, step;
    logic [PROG_W-1:0] prog;

    wbcap_regs #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .prog(prog),
        .base(base), .stride(stride), .height(height), .ctrl(ctrl),
        .go_req(go_req), .abort_req(abort_req)
    );

    wbcap_frame u_frame (
        .clk(clk), .rst_n(rst_n), .go_req(go_req), .abort_req(abort_req),
        .line_done(line_done), .height(height), .ctrl(ctrl), .busy(busy),
        .prog(prog), .frame_start(frame_start), .irq(irq), .load(load), .step(step)
    );

    wbcap_addr #(.PTR_W(PTR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step), .base(base),
        .stride(stride), .line_addr(line_addr)
    );

    assign frame_busy = busy;
    assign mem_sleep  = ctrl.sleep;
endmodule

// File: rtl/wbcap_ctrl_chk.sv
// Property checker for wbcap_ctrl, attached by bind. It observes the
// command decode, the sequencer state and the ports.
module wbcap_ctrl_chk
    import wbcap_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int PTR_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic [PROG_W-1:0] prog,
    input logic [15:0]       height,
    input logic              go_req,
    input logic              abort_req,
    input logic              line_done,
    input logic [PTR_W-1:0]  line_addr,
    input logic [PTR_W-1:0]  stride,
    input logic              irq,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_rdata
);
    assert_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && go_req && !abort_req && height != 16'd0) |=> (busy && prog == '0));

    assert_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && line_done && !abort_req) |=> (prog == $past(prog) + PROG_W'(1)));

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && line_done && !abort_req) |=> (line_addr == $past(line_addr) + $past(stride)));

    assert_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (prog < PROG_W'(height)));

    assert_go_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && go_req && !abort_req && !line_done) |=> (busy && $stable(prog)));

    assert_idle_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && line_done && !go_req) |=> ($stable(prog) && $stable(line_addr)));

    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort_req) |=> (!busy && $stable(prog)));

    assert_irq_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy);

    assert_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(IDX_CTRL * 4)) |-> (reg_rdata[31:22] == 10'h151));
endmodule

bind wbcap_ctrl wbcap_ctrl_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .prog(prog), .height(height),
    .go_req(go_req), .abort_req(abort_req), .line_done(line_done),
    .line_addr(line_addr), .stride(stride), .irq(irq), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata)
);

// File: tb/wbcap_ctrl_tb.sv
// Self-checking bench: register sweeps and frame sweeps at PTR_W = 16.
module wbcap_ctrl_tb;
    localparam int ADDR_W = 5;
    localparam int PTR_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              line_done = 1'b0;
    logic [PTR_W-1:0]  line_addr;
    logic              frame_start, frame_busy, mem_sleep, irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    wbcap_ctrl #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_done(line_done),
        .line_addr(line_addr), .frame_start(frame_start), .frame_busy(frame_busy),
        .mem_sleep(mem_sleep), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_line();
        @(negedge clk);
        line_done = 1'b1;
        @(negedge clk);
        line_done = 1'b0;
    endtask

    localparam logic [31:0] ID_WORD = 32'h5440_0000;
    localparam logic [31:0] C_GO = 32'h1, C_IE = 32'h4, C_AB = 32'h4000,
                            C_RE = 32'h8000, C_SL = 32'h20_0000;

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [15:0] bases [2];
        logic [15:0] strides [3];
        bases[0] = 16'h0040; bases[1] = 16'hFF00;
        strides[0] = 16'h0010; strides[1] = 16'h0030; strides[2] = 16'h01F0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int i = 0; i < 5; i++) begin
            rd(ADDR_W'(i * 4), v);
            chk("R1 reg", v, (i == 3) ? ID_WORD : 32'h0);
        end
        chk("R1 outputs", {frame_busy, irq, frame_start, mem_sleep}, 0);
        chk("R1 line_addr", 32'(line_addr), 0);

        // R2: alignment and size field
        wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, v); chk("R2 base", v, 32'h0000_FFFC);
        wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, v); chk("R2 stride", v, 32'h0000_FFF0);
        wr(5'h08, 32'h1234_5678); rd(5'h08, v); chk("R2 size", v, 32'h1234_5678);

        // R14: unmapped and misaligned offsets
        wr(5'h14, 32'hFFFF_FFFF); wr(5'h09, 32'h0);
        rd(5'h14, v); chk("R14 unmapped read", v, 0);
        rd(5'h1C, v); chk("R14 unmapped read", v, 0);
        rd(5'h0A, v); chk("R14 misaligned read", v, 0);
        rd(5'h08, v); chk("R14 size untouched", v, 32'h1234_5678);

        // R3 and R12: control readback and sleep
        wr(5'h0C, 32'hFFFF_BFFE); rd(5'h0C, v);
        chk("R3 ctrl readback", v, ID_WORD | C_SL | C_RE | C_IE);
        chk("R12 mem_sleep on", 32'(mem_sleep), 1);
        chk("R12 busy idle", 32'(frame_busy), 0);
        wr(5'h0C, 32'h0); rd(5'h0C, v);
        chk("R3 ctrl cleared", v, ID_WORD);
        chk("R12 mem_sleep off", 32'(mem_sleep), 0);

        // R4..R8, R10, R11, R13: frame sweep
        for (int b = 0; b < 2; b++)
        for (int s = 0; s < 3; s++)
        for (int h = 1; h <= 4; h++)
        for (int re = 0; re < 2; re++) begin
            logic [31:0] cw;
            cw = C_IE | (re ? C_RE : 32'h0);
            wr(5'h00, 32'(bases[b]));
            wr(5'h04, 32'(strides[s]));
            wr(5'h08, {16'(h), 16'd7});
            wr(5'h0C, cw | C_GO);
            chk("R4 busy", 32'(frame_busy), 1);
            chk("R4 frame_start", 32'(frame_start), 1);
            chk("R4 line_addr", 32'(line_addr), 32'(bases[b]));
            chk("R10 irq low on start", 32'(irq), 0);
            rd(5'h10, v); chk("R4 progress", v, 0);
            rd(5'h0C, v); chk("R3 busy bit", v, ID_WORD | cw | 32'h2);
            for (int k = 1; k <= h; k++) begin
                pulse_line();
                rd(5'h10, v); chk("R5 progress", v, 32'(k));
                chk("R5 line_addr", 32'(line_addr),
                    32'(16'(bases[b] + 16'(k) * strides[s])));
                if (k < h) begin
                    chk("R6 busy mid", 32'(frame_busy), 1);
                    chk("R4 pulse one cycle", 32'(frame_start), 0);
                    if (k == 1) begin
                        wr(5'h0C, cw | C_GO);
                        rd(5'h10, v); chk("R7 go while busy", v, 1);
                        chk("R7 still busy", 32'(frame_busy), 1);
                        wr(5'h00, 32'h0000_1234);
                        rd(5'h00, v); chk("R13 base frozen", v, 32'(bases[b]));
                    end
                end else begin
                    chk("R6 busy clear", 32'(frame_busy), 0);
                    chk("R11 rearm pulse", 32'(frame_start), 32'(re));
                    chk("R10 irq", 32'(irq), 1);
                end
            end
            @(negedge clk);
            chk("R11 pulse one cycle", 32'(frame_start), 0);
            pulse_line();
            rd(5'h10, v); chk("R8 idle progress", v, 32'(h));
            chk("R8 idle line_addr", 32'(line_addr),
                32'(16'(bases[b] + 16'(h) * strides[s])));
            if (b == 0 && s == 0 && h == 1 && re == 0) begin
                wr(5'h0C, C_IE | C_GO);
                chk("R10 irq cleared by start", 32'(irq), 0);
                pulse_line();
            end
            wr(5'h0C, 32'h0);
            chk("R10 irq ack", 32'(irq), 0);
        end

        // R9: abort mid frame, rearm set
        wr(5'h00, 32'h0100); wr(5'h04, 32'h0020); wr(5'h08, 32'h000A_0000);
        wr(5'h0C, C_IE | C_RE | C_GO);
        pulse_line(); pulse_line(); pulse_line();
        wr(5'h0C, C_IE | C_RE | C_AB);
        chk("R9 busy cleared", 32'(frame_busy), 0);
        chk("R11 no pulse on abort", 32'(frame_start), 0);
        chk("R10 irq after abort", 32'(irq), 1);
        rd(5'h10, v); chk("R9 progress held", v, 3);
        pulse_line();
        rd(5'h10, v); chk("R9 later strobe ignored", v, 3);
        chk("R9 line_addr held", 32'(line_addr), 32'h0160);

        // R9: start with abort while idle is ignored
        wr(5'h0C, C_GO | C_AB);
        chk("R9 go with abort", 32'(frame_busy), 0);
        chk("R9 no start pulse", 32'(frame_start), 0);

        // R7: zero line count
        wr(5'h08, 32'h0000_0040);
        wr(5'h0C, C_GO);
        chk("R7 zero height", 32'(frame_busy), 0);
        chk("R7 zero height pulse", 32'(frame_start), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule